// File: doc/BRIEF.md
# Single-Input Router Packet Controller

This block is the sequencing controller for a router that takes packets on one byte-wide input and steers each one into one of several output channel queues. It watches the sender's valid flag, the channel address carried by the header byte, and the empty and full flags of the queue that the address selects. From these it walks each packet through its phases and raises one strobe per phase. The strobes tell a separate datapath which byte to capture, when to write the selected queue, when to hold the sender off, and when to clear its per-packet registers.

The controller has eight states:

| State | Role |
|---|---|
| `S_ADDR` | Idle state; decodes the address. |
| `S_WAIT` | Waits until the selected queue drains. |
| `S_HDR` | Captures the header. |
| `S_PAY` | Streams the payload. |
| `S_PAR` | Takes the parity byte. |
| `S_FULL` | Stalls while the queue is full. |
| `S_RESUME` | Writes the byte held during the stall. |
| `S_CHECK` | One-cycle parity-check and clear. |

The transitions are:

| Transition | Condition |
|---|---|
| `ADDR→HDR` | Valid, address in range, queue empty. |
| `ADDR→WAIT` | Valid, address in range, queue not empty. |
| `WAIT→HDR` | Queue empty. |
| `HDR→PAY` | Always. |
| `PAY→FULL` | Queue full. |
| `PAY→PAR` | Valid dropped and queue not full. |
| `PAR→CHECK` | Queue not full. |
| `PAR→FULL` | Queue full. |
| `FULL→RESUME` | Queue no longer full. |
| `RESUME→ADDR` | Parity done. |
| `RESUME→PAR` | Late-valid set. |
| `RESUME→PAY` | Otherwise. |
| `CHECK→ADDR` | Always. |

All other cases hold the current state. Outputs are decoded from the registered state, so each strobe reflects the state entered at the most recent clock edge.

Top module: `rfsm_router_ctrl`

## Requirements
- R1: A low `rst_n` at a rising edge places the controller in `S_ADDR`. In that state `addr_detect` is 1 and every other output is 0.
- R2: In `S_ADDR`, `pkt_valid`=1 with `hdr_addr` below `NUM_CH` (3 by default) moves to `S_HDR` if `sel_empty`=1, and to `S_WAIT` if `sel_empty`=0.
- R3: `S_WAIT` stays put while `sel_empty`=0 and moves to `S_HDR` once `sel_empty`=1. In `S_WAIT`, `stall`=1, `wr_en`=0 and no phase strobe is set.
- R4: `S_HDR` drives `hdr_latch`=1 and `stall`=1 with `wr_en`=0, and moves to `S_PAY` on the next edge regardless of inputs.
- R5: `S_PAY` drives `pay_latch`=1, `wr_en`=1 and `stall`=0. It goes to `S_FULL` if `sel_full`=1, to `S_PAR` if `pkt_valid`=0 and `sel_full`=0, and otherwise stays.
- R6: `S_PAR` drives `par_latch`=1, `wr_en`=1 and `stall`=1. It goes to `S_CHECK` if `sel_full`=0 and to `S_FULL` if `sel_full`=1.
- R7: `S_FULL` drives `full_hold`=1, `stall`=1 and `wr_en`=0. It stays while `sel_full`=1 and moves to `S_RESUME` when `sel_full`=0.
- R8: `S_RESUME` drives `resume_latch`=1, `wr_en`=1 and `stall`=1. It goes to `S_ADDR` if `par_done`=1, to `S_PAR` if `par_done`=0 and `late_valid`=1, and to `S_PAY` if both are 0.
- R9: `S_CHECK` drives `clear_regs`=1, `stall`=1 and `wr_en`=0, and returns to `S_ADDR` on the next edge regardless of inputs.
- R10: In `S_ADDR`, `pkt_valid`=0, or an address of `NUM_CH` or above (3 by default), leaves the controller in `S_ADDR`.
- R11: At most one of `addr_detect`, `hdr_latch`, `pay_latch`, `par_latch`, `full_hold`, `resume_latch` and `clear_regs` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_valid | input | 1 | Sender's packet valid flag |
| hdr_addr | input | ADDR_W (2) | Channel address bits taken from the header byte |
| sel_empty | input | 1 | Selected channel queue is empty |
| sel_full | input | 1 | Selected channel queue is full |
| par_done | input | 1 | Datapath has already captured the parity byte |
| late_valid | input | 1 | Datapath saw valid drop while stalled |
| addr_detect | output | 1 | Idle/decode phase: latch address and header |
| hdr_latch | output | 1 | Header byte capture strobe |
| pay_latch | output | 1 | Payload byte capture strobe |
| par_latch | output | 1 | Parity byte capture strobe |
| full_hold | output | 1 | Hold the byte in flight while the queue is full |
| resume_latch | output | 1 | Write the held byte after the stall |
| clear_regs | output | 1 | Clear datapath per-packet registers |
| stall | output | 1 | Tell the sender to stop presenting new bytes |
| wr_en | output | 1 | Write the selected channel queue |

## Verification
The assertions check these properties on every cycle:
- the strobes never overlap;
- the header and check states always last one cycle;
- a full queue seen during payload or parity always leads to the stall state, and the stall state holds while the queue stays full;
- the wait state holds while the queue is non-empty;
- an out-of-range address never leaves the idle state;
- the stall and write-enable values match each state.

Only the bench scenarios show the complete packet paths, which are:
- direct and delayed header entry;
- a payload run ending in a parity check;
- stalls during payload and during parity;
- every exit from the resume state;
- a reset in the middle of a packet.

// File: rtl/rfsm_pkg.sv
package rfsm_pkg;

    typedef enum logic [2:0] {
        S_ADDR   = 3'd0,
        S_WAIT   = 3'd1,
        S_HDR    = 3'd2,
        S_PAY    = 3'd3,
        S_PAR    = 3'd4,
        S_FULL   = 3'd5,
        S_RESUME = 3'd6,
        S_CHECK  = 3'd7
    } rfsm_state_e;

endpackage

// File: rtl/rfsm_next.sv
module rfsm_next
    import rfsm_pkg::*;
(
    input  rfsm_state_e state,
    input  logic        pkt_valid,
    input  logic        addr_ok,
    input  logic        sel_empty,
    input  logic        sel_full,
    input  logic        par_done,
    input  logic        late_valid,
    output rfsm_state_e next_state
);

    always_comb begin
        next_state = state;
        unique case (state)
            S_ADDR: begin
                if (pkt_valid && addr_ok)
                    next_state = sel_empty ? S_HDR : S_WAIT;
            end
            S_WAIT: begin
                if (sel_empty)
                    next_state = S_HDR;
            end
            S_HDR: begin
                next_state = S_PAY;
            end
            S_PAY: begin
                if (sel_full)
                    next_state = S_FULL;
                else if (!pkt_valid)
                    next_state = S_PAR;
            end
            S_PAR: begin
                next_state = sel_full ? S_FULL : S_CHECK;
            end
            S_FULL: begin
                if (!sel_full)
                    next_state = S_RESUME;
            end
            S_RESUME: begin
                if (par_done)
                    next_state = S_ADDR;
                else if (late_valid)
                    next_state = S_PAR;
                else
                    next_state = S_PAY;
            end
            S_CHECK: begin
                next_state = S_ADDR;
            end
            default: next_state = S_ADDR;
        endcase
    end

endmodule

// File: rtl/rfsm_decode.sv
module rfsm_decode
    import rfsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rfsm_state_e state,
    output logic        addr_detect,
    output logic        hdr_latch,
    output logic        pay_latch,
    output logic        par_latch,
    output logic        full_hold,
    output logic        resume_latch,
    output logic        clear_regs,
    output logic        stall,
    output logic        wr_en
);

    always_comb begin
        addr_detect  = 1'b0;
        hdr_latch    = 1'b0;
        pay_latch    = 1'b0;
        par_latch    = 1'b0;
        full_hold    = 1'b0;
        resume_latch = 1'b0;
        clear_regs   = 1'b0;
        stall        = 1'b1;
        wr_en        = 1'b0;
        unique case (state)
            S_ADDR:   begin addr_detect  = 1'b1; stall = 1'b0; end
            S_WAIT:   begin end
            S_HDR:    begin hdr_latch    = 1'b1; end
            S_PAY:    begin pay_latch    = 1'b1; stall = 1'b0; wr_en = 1'b1; end
            S_PAR:    begin par_latch    = 1'b1; wr_en = 1'b1; end
            S_FULL:   begin full_hold    = 1'b1; end
            S_RESUME: begin resume_latch = 1'b1; wr_en = 1'b1; end
            S_CHECK:  begin clear_regs   = 1'b1; end
            default:  begin addr_detect  = 1'b1; stall = 1'b0; end
        endcase
    end

    // R11: phase strobes never overlap
    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_detect, hdr_latch, pay_latch, par_latch,
                  full_hold, resume_latch, clear_regs}));

    // R7, R9: the stall and check states never write the queue
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hold || clear_regs) |-> !wr_en);

    // R5: the sender is released only in idle and payload
    assert_stall_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (addr_detect || pay_latch));

endmodule

// File: rtl/rfsm_router_ctrl.sv
module rfsm_router_ctrl
    import rfsm_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic              sel_empty,
    input  logic              sel_full,
    input  logic              par_done,
    input  logic              late_valid,
    output logic              addr_detect,
    output logic              hdr_latch,
    output logic              pay_latch,
    output logic              par_latch,
    output logic              full_hold,
    output logic              resume_latch,
    output logic              clear_regs,
    output logic              stall,
    output logic              wr_en
);

    rfsm_state_e state_q;
    rfsm_state_e state_d;
    logic        addr_ok;

    assign addr_ok = (int'(hdr_addr) < NUM_CH);

    rfsm_next u_next (
        .state      (state_q),
        .pkt_valid  (pkt_valid),
        .addr_ok    (addr_ok),
        .sel_empty  (sel_empty),
        .sel_full   (sel_full),
        .par_done   (par_done),
        .late_valid (late_valid),
        .next_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_ADDR;
        else
            state_q <= state_d;
    end

    rfsm_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state_q),
        .addr_detect  (addr_detect),
        .hdr_latch    (hdr_latch),
        .pay_latch    (pay_latch),
        .par_latch    (par_latch),
        .full_hold    (full_hold),
        .resume_latch (resume_latch),
        .clear_regs   (clear_regs),
        .stall        (stall),
        .wr_en        (wr_en)
    );

    // R4: the header phase lasts exactly one cycle
    assert_hdr_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_latch |=> pay_latch);

    // R9: the check phase returns to idle
    assert_check_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_regs |=> addr_detect);

    // R5, R6: a full queue during payload or parity leads to the stall state
    assert_full_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pay_latch || par_latch) && sel_full) |=> full_hold);

    // R7: the stall state holds while the queue stays full
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hold && sel_full) |=> full_hold);

    // R3: the wait state holds while the queue is non-empty
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wr_en && !hdr_latch && !full_hold && !clear_regs && !sel_empty)
        |=> (stall && !wr_en && !hdr_latch && !full_hold && !clear_regs));

    // R10: an out-of-range address keeps the controller idle
    assert_bad_addr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_detect && int'(hdr_addr) >= NUM_CH) |=> addr_detect);

endmodule

// File: tb/rfsm_router_ctrl_tb.sv
module rfsm_router_ctrl_tb_top;

    // Order: {addr, hdr, pay, par, full, resume, clear, stall, wr}
    localparam logic [8:0] V_ADDR = 9'b100000000;
    localparam logic [8:0] V_WAIT = 9'b000000010;
    localparam logic [8:0] V_HDR  = 9'b010000010;
    localparam logic [8:0] V_PAY  = 9'b001000001;
    localparam logic [8:0] V_PAR  = 9'b000100011;
    localparam logic [8:0] V_FULL = 9'b000010010;
    localparam logic [8:0] V_RES  = 9'b000001011;
    localparam logic [8:0] V_CHK  = 9'b000000110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [1:0] hdr_addr = 2'd0;
    logic       sel_empty = 1'b1;
    logic       sel_full = 1'b0;
    logic       par_done = 1'b0;
    logic       late_valid = 1'b0;
    logic       addr_detect, hdr_latch, pay_latch, par_latch;
    logic       full_hold, resume_latch, clear_regs, stall, wr_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rfsm_router_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .hdr_addr(hdr_addr),
        .sel_empty(sel_empty), .sel_full(sel_full), .par_done(par_done),
        .late_valid(late_valid), .addr_detect(addr_detect), .hdr_latch(hdr_latch),
        .pay_latch(pay_latch), .par_latch(par_latch), .full_hold(full_hold),
        .resume_latch(resume_latch), .clear_regs(clear_regs), .stall(stall),
        .wr_en(wr_en)
    );

    wire [8:0] obs = {addr_detect, hdr_latch, pay_latch, par_latch, full_hold,
                      resume_latch, clear_regs, stall, wr_en};

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: apply inputs at the falling edge and queue the expected outputs
    // for the state entered at the following rising edge.
    task automatic drive(input logic rst, input logic v, input logic [1:0] a,
                         input logic emp, input logic ful, input logic pd,
                         input logic lv, input logic [8:0] exp, input string tag);
        @(negedge clk);
        rst_n = rst; pkt_valid = v; hdr_addr = a; sel_empty = emp;
        sel_full = ful; par_done = pd; late_valid = lv;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (obs !== e) begin
                errors++;
                $display("FAIL %s: actual %b expected %b", t, obs, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1 reset
        drive(0, 1, 2'd1, 0, 1, 1, 1, V_ADDR, "R1 reset");
        drive(0, 0, 2'd0, 1, 0, 0, 0, V_ADDR, "R1 reset hold");
        // R10 idle cases
        drive(1, 0, 2'd1, 1, 0, 0, 0, V_ADDR, "R10 valid low");
        drive(1, 1, 2'd3, 1, 0, 0, 0, V_ADDR, "R10 addr 3 empty");
        drive(1, 1, 2'd3, 0, 0, 0, 0, V_ADDR, "R10 addr 3 nonempty");
        // Packet A: direct entry, payload, parity, check
        drive(1, 1, 2'd1, 1, 0, 0, 0, V_HDR,  "R2 to header");
        drive(1, 1, 2'd1, 0, 1, 0, 0, V_PAY,  "R4 header unconditional");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_PAY,  "R5 payload stays");
        drive(1, 0, 2'd0, 0, 0, 0, 0, V_PAR,  "R5 valid drop to parity");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_CHK,  "R6 parity to check");
        drive(1, 1, 2'd0, 1, 1, 0, 0, V_ADDR, "R9 check to idle");
        // Packet B: wait for empty, stall, resume to payload, stall in parity
        drive(1, 1, 2'd2, 0, 0, 0, 0, V_WAIT, "R2 to wait");
        drive(1, 1, 2'd2, 0, 0, 0, 0, V_WAIT, "R3 wait holds");
        drive(1, 1, 2'd2, 1, 0, 0, 0, V_HDR,  "R3 wait to header");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_PAY,  "R4 header to payload");
        drive(1, 1, 2'd0, 0, 1, 0, 0, V_FULL, "R5 payload to full");
        drive(1, 1, 2'd0, 0, 1, 0, 0, V_FULL, "R7 full holds");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_RES,  "R7 full to resume");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_PAY,  "R8 resume to payload");
        drive(1, 0, 2'd0, 0, 0, 0, 0, V_PAR,  "R5 to parity");
        drive(1, 0, 2'd0, 0, 1, 0, 0, V_FULL, "R6 parity to full");
        drive(1, 0, 2'd0, 0, 0, 0, 0, V_RES,  "R7 to resume");
        drive(1, 0, 2'd0, 0, 0, 0, 1, V_PAR,  "R8 resume late valid");
        drive(1, 0, 2'd0, 0, 0, 0, 0, V_CHK,  "R6 to check");
        drive(1, 0, 2'd0, 0, 0, 0, 0, V_ADDR, "R9 to idle");
        // Packet C: resume with parity done returns to idle
        drive(1, 1, 2'd0, 1, 0, 0, 0, V_HDR,  "R2 header ch0");
        drive(1, 1, 2'd0, 0, 0, 0, 0, V_PAY,  "R4 payload");
        drive(1, 1, 2'd0, 0, 1, 0, 0, V_FULL, "R5 full");
        drive(1, 0, 2'd0, 0, 0, 1, 1, V_RES,  "R7 resume");
        drive(1, 0, 2'd0, 0, 0, 1, 1, V_ADDR, "R8 parity done to idle");
        // Packet D: reset in the middle of the payload
        drive(1, 1, 2'd2, 1, 0, 0, 0, V_HDR,  "R2 header ch2");
        drive(1, 1, 2'd2, 0, 0, 0, 0, V_PAY,  "R4 payload ch2");
        drive(0, 1, 2'd2, 0, 0, 0, 0, V_ADDR, "R1 reset mid packet");
        drive(1, 0, 2'd2, 0, 0, 0, 0, V_ADDR, "R10 idle after reset");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule